// File: doc/BRIEF.md
# Magic Packet Wake Detector

This block sits behind a receive path and watches each incoming Ethernet frame as a byte stream, one byte per `rx_valid` beat, with `rx_sof` marking the first byte and `rx_eof` the last. Once the twelve bytes of destination and source address have gone by, it searches the rest of the frame for a wake pattern: a run of six `0xFF` bytes, followed at once by sixteen back-to-back copies of the station's own 48-bit address. The pattern may begin at any byte offset. A partial match that breaks does not end the search; it starts again from the failing byte.

The search result only matters at end of frame. On the last beat, the frame-good verdict from an external CRC checker and the power-state gating together decide whether a wake is reported. The gating rules are:

- In power state D0, detection depends on a software enable bit.
- In D1, detection is always armed.
- In any other state, detection is off.

A reported wake gives a one-cycle `wake_pulse` and sets the sticky `wake_sts`, which stays high until `sts_clr` clears it.

The scanner is a named state machine:

- States: `SC_IDLE`, `SC_HDR`, `SC_SYNC`, `SC_ADDR` and `SC_FOUND`.
- Start of frame moves any state to `SC_HDR`. When the twelfth byte has passed, `SC_HDR` moves to `SC_SYNC`.
- A complete sync run moves `SC_SYNC` to `SC_ADDR`. A byte that does not match sends `SC_ADDR` back to `SC_SYNC`. The last byte of the sixteenth copy moves `SC_ADDR` to `SC_FOUND`.
- End of frame moves any state to `SC_IDLE`, and takes priority over start of frame.

Top module: `magic_wake_det`

## Requirements
- R1: When a beat with `rx_valid` and `rx_eof` is sampled, and the pattern was found earlier in that frame, `frame_good` is high and detection is armed, `wake_pulse` is high for exactly the one following clock cycle.
- R2: The pattern is six consecutive `0xFF` bytes, followed immediately by 16 consecutive copies of `station_addr`. Each copy is sent most significant byte first (`station_addr[47:40]` first). Fewer copies, or any single wrong byte, gives no wake.
- R3: The pattern may start at any byte offset after the header. Extra `0xFF` bytes before the last six of the sync run are allowed.
- R4: A broken partial match restarts the search. If the byte that breaks the address sequence is `0xFF`, it counts as the first byte of a new sync run.
- R5: After reset, `wake_pulse` and `wake_sts` are low. A reported wake sets `wake_sts` in the same cycle that `wake_pulse` rises.
- R6: With `pwr_state` = 2'b00 (D0), a wake is reported only if `wake_en` is high in the end-of-frame beat.
- R7: With `pwr_state` = 2'b01 (D1), a wake is reported whatever the value of `wake_en`.
- R8: With `pwr_state` = 2'b10 or 2'b11, no wake is reported.
- R9: A frame whose `frame_good` is low in the end-of-frame beat reports no wake, even if the pattern was found.
- R10: The first 12 bytes of a frame (the destination and source addresses) are not scanned. A pattern that begins inside them is not found.
- R11: `wake_sts` stays high until a cycle in which `sts_clr` is sampled high. If a new wake is reported in that same cycle, the set wins.
- R12: A start-of-frame beat discards any match progress from before it, including a found pattern in a frame that never ended.
- R13: A match that completes on the end-of-frame beat itself is not reported, because that byte belongs to the CRC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Byte strobe |
| rx_sof | input | 1 | First byte of frame (qualified by rx_valid) |
| rx_eof | input | 1 | Last byte of frame (qualified by rx_valid) |
| rx_byte | input | 8 | Received byte |
| frame_good | input | 1 | CRC verdict, sampled on the end-of-frame beat |
| station_addr | input | 48 | Own station address, bits 47:40 sent first |
| pwr_state | input | 2 | 00 D0, 01 D1, 10/11 other |
| wake_en | input | 1 | Software enable, used in D0 |
| sts_clr | input | 1 | Clears the sticky status |
| wake_pulse | output | 1 | One-cycle wake event |
| wake_sts | output | 1 | Sticky wake status |

## Verification
The sticky status has two functions that can fall in the same cycle: its set, from a wake reported at end of frame, and its clear, from `sts_clr`. The bench provokes the collision by raising `sts_clr` on exactly the end-of-frame beat of a qualifying frame. It then requires `wake_sts` to read high afterwards, since the set takes precedence. A second collision, between a pattern that completes and the end-of-frame beat it completes on, is provoked by ending a frame on the last address byte. That case must report nothing.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [2:0] {
        SC_IDLE,
        SC_HDR,
        SC_SYNC,
        SC_ADDR,
        SC_FOUND
    } scan_state_t;

    typedef enum logic [1:0] {
        PW_D0  = 2'b00,
        PW_D1  = 2'b01,
        PW_D2  = 2'b10,
        PW_D3  = 2'b11
    } pwr_state_t;

    localparam logic [7:0] SYNC_BYTE = 8'hFF;

endpackage

// File: rtl/mw_power_gate.sv
module mw_power_gate
    import mw_pkg::*;
(
    input  logic [1:0] pwr_state,
    input  logic       wake_en,
    output logic       armed
);

    pwr_state_t ps;

    always_comb begin
        ps = pwr_state_t'(pwr_state);
        unique case (ps)
            PW_D0:   armed = wake_en;
            PW_D1:   armed = 1'b1;
            PW_D2:   armed = 1'b0;
            PW_D3:   armed = 1'b0;
            default: armed = 1'b0;
        endcase
    end

    // R8: states other than D0/D1 never arm detection
    always_comb begin
        if (pwr_state[1]) begin
            assert (!armed) else $error("p_off_state_r8");
        end
    end

endmodule

// File: rtl/mw_scanner.sv
module mw_scanner
    import mw_pkg::*;
#(
    parameter int HDR_BYTES  = 12,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_BYTES = 6,
    parameter int REPEATS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_byte,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    output logic                    found
);

    localparam int HDR_W  = $clog2(HDR_BYTES);
    localparam int SYNC_W = $clog2(SYNC_LEN);
    localparam int IDX_W  = $clog2(ADDR_BYTES);
    localparam int REP_W  = $clog2(REPEATS);

    localparam logic [HDR_W-1:0]  HDR_LAST  = HDR_W'(HDR_BYTES - 1);
    localparam logic [SYNC_W-1:0] SYNC_LAST = SYNC_W'(SYNC_LEN - 1);
    localparam logic [IDX_W-1:0]  IDX_LAST  = IDX_W'(ADDR_BYTES - 1);
    localparam logic [REP_W-1:0]  REP_LAST  = REP_W'(REPEATS - 1);

    scan_state_t       state_q, state_d;
    logic [HDR_W-1:0]  hdr_q,  hdr_d;
    logic [SYNC_W-1:0] ff_q,   ff_d;
    logic [IDX_W-1:0]  idx_q,  idx_d;
    logic [REP_W-1:0]  rep_q,  rep_d;
    logic [7:0]        exp_byte;
    logic              is_sync;
    logic              addr_hit;

    // expected address byte: most significant byte travels first
    always_comb begin
        exp_byte = station_addr[(ADDR_BYTES - 1 - int'(idx_q)) * 8 +: 8];
        is_sync  = (rx_byte == SYNC_BYTE);
        addr_hit = (rx_byte == exp_byte);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        hdr_d   = hdr_q;
        ff_d    = ff_q;
        idx_d   = idx_q;
        rep_d   = rep_q;
        if (rx_valid) begin
            if (rx_eof) begin
                state_d = SC_IDLE;
            end else if (rx_sof) begin
                state_d = SC_HDR;
                hdr_d   = HDR_W'(1);
            end else begin
                unique case (state_q)
                    SC_IDLE: begin
                        state_d = SC_IDLE;
                    end
                    SC_HDR: begin
                        if (hdr_q == HDR_LAST) begin
                            state_d = SC_SYNC;
                            ff_d    = '0;
                        end else begin
                            hdr_d = hdr_q + HDR_W'(1);
                        end
                    end
                    SC_SYNC: begin
                        if (is_sync) begin
                            if (ff_q == SYNC_LAST) begin
                                state_d = SC_ADDR;
                                idx_d   = '0;
                                rep_d   = '0;
                            end else begin
                                ff_d = ff_q + SYNC_W'(1);
                            end
                        end else begin
                            ff_d = '0;
                        end
                    end
                    SC_ADDR: begin
                        if (addr_hit) begin
                            if (idx_q == IDX_LAST) begin
                                idx_d = '0;
                                if (rep_q == REP_LAST) begin
                                    state_d = SC_FOUND;
                                end else begin
                                    rep_d = rep_q + REP_W'(1);
                                end
                            end else begin
                                idx_d = idx_q + IDX_W'(1);
                            end
                        end else if (is_sync) begin
                            if (idx_q == '0 && rep_q == '0) begin
                                state_d = SC_ADDR;  // sync run keeps going
                            end else begin
                                state_d = SC_SYNC;
                                ff_d    = SYNC_W'(1);
                            end
                        end else begin
                            state_d = SC_SYNC;
                            ff_d    = '0;
                        end
                    end
                    SC_FOUND: begin
                        state_d = SC_FOUND;
                    end
                    default: begin
                        state_d = SC_IDLE;
                    end
                endcase
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SC_IDLE;
            hdr_q   <= '0;
            ff_q    <= '0;
            idx_q   <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            hdr_q   <= hdr_d;
            ff_q    <= ff_d;
            idx_q   <= idx_d;
            rep_q   <= rep_d;
        end
    end

    // outputs
    always_comb begin
        found = (state_q == SC_FOUND);
    end

    // R12: a start-of-frame beat (not also end) always restarts header skip
    p_sof_restart_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_sof && !rx_eof) |=> (state_q == SC_HDR));

    // R2: FOUND can only be entered from address comparison
    p_found_from_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_eof && !rx_sof && state_q == SC_SYNC) |=> (state_q != SC_FOUND));

    // R2: byte index stays inside the address
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SC_ADDR) |-> (int'(idx_q) < ADDR_BYTES));

    // R13: an end-of-frame beat always returns the scanner to idle
    p_eof_idle_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && rx_eof) |=> (state_q == SC_IDLE));

endmodule

// File: rtl/mw_report.sv
module mw_report (
    input  logic clk,
    input  logic rst_n,
    input  logic eof_beat,
    input  logic found,
    input  logic frame_good,
    input  logic armed,
    input  logic sts_clr,
    output logic wake_pulse,
    output logic wake_sts
);

    logic fire;

    always_comb begin
        fire = eof_beat & found & frame_good & armed;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_pulse <= 1'b0;
            wake_sts   <= 1'b0;
        end else begin
            wake_pulse <= fire;
            wake_sts   <= fire | (wake_sts & ~sts_clr);
        end
    end

    // R1: the pulse never lasts two cycles
    p_pulse_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R5: status is high whenever the pulse is
    p_pulse_sets_sts_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |-> wake_sts);

    // R11: without a clear, the status holds
    p_sticky_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_sts && !sts_clr) |=> wake_sts);

    // R9: a pulse follows only a good-CRC end-of-frame beat
    p_good_crc_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> ($past(frame_good) && $past(eof_beat)));

endmodule

// File: rtl/magic_wake_det.sv
module magic_wake_det
    import mw_pkg::*;
#(
    parameter int HDR_BYTES  = 12,
    parameter int SYNC_LEN   = 6,
    parameter int ADDR_BYTES = 6,
    parameter int REPEATS    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rx_valid,
    input  logic                    rx_sof,
    input  logic                    rx_eof,
    input  logic [7:0]              rx_byte,
    input  logic                    frame_good,
    input  logic [ADDR_BYTES*8-1:0] station_addr,
    input  logic [1:0]              pwr_state,
    input  logic                    wake_en,
    input  logic                    sts_clr,
    output logic                    wake_pulse,
    output logic                    wake_sts
);

    logic armed;
    logic found;
    logic eof_beat;

    always_comb begin
        eof_beat = rx_valid & rx_eof;
    end

    mw_power_gate u_gate (
        .pwr_state (pwr_state),
        .wake_en   (wake_en),
        .armed     (armed)
    );

    mw_scanner #(
        .HDR_BYTES  (HDR_BYTES),
        .SYNC_LEN   (SYNC_LEN),
        .ADDR_BYTES (ADDR_BYTES),
        .REPEATS    (REPEATS)
    ) u_scan (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_byte      (rx_byte),
        .station_addr (station_addr),
        .found        (found)
    );

    mw_report u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .eof_beat   (eof_beat),
        .found      (found),
        .frame_good (frame_good),
        .armed      (armed),
        .sts_clr    (sts_clr),
        .wake_pulse (wake_pulse),
        .wake_sts   (wake_sts)
    );

    // R6/R7/R8: a pulse requires detection armed on the previous beat
    p_pulse_armed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_pulse) |-> $past(armed));

endmodule

// File: tb/tb_magic_wake_det.sv
module tb_magic_wake_det;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic [7:0]  rx_byte = 8'h00;
    logic        frame_good = 1'b1;
    logic [47:0] station_addr = 48'h021A3C4D5E6F;
    logic [1:0]  pwr_state = 2'b00;
    logic        wake_en = 1'b1;
    logic        sts_clr = 1'b0;
    logic        wake_pulse;
    logic        wake_sts;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [7:0] frm [256];
    int         flen;

    always #5 clk = ~clk;

    magic_wake_det dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_byte      (rx_byte),
        .frame_good   (frame_good),
        .station_addr (station_addr),
        .pwr_state    (pwr_state),
        .wake_en      (wake_en),
        .sts_clr      (sts_clr),
        .wake_pulse   (wake_pulse),
        .wake_sts     (wake_sts)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        frm[flen] = b;
        flen++;
    endtask

    task automatic start_frame();
        flen = 0;
        for (int i = 0; i < 12; i++) put(8'h20 + 8'(i));
    endtask

    task automatic put_sync(input int n);
        for (int i = 0; i < n; i++) put(8'hFF);
    endtask

    // copies of the address; if bad_pos >= 0 that byte position is corrupted
    task automatic put_copies(input int n, input int bad_pos);
        int p = 0;
        for (int c = 0; c < n; c++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] b = station_addr[(5 - k) * 8 +: 8];
                if (p == bad_pos) b = b ^ 8'h01;
                put(b);
                p++;
            end
        end
    endtask

    task automatic put_crc();
        put(8'h5A); put(8'hC3); put(8'h11); put(8'h7E);
    endtask

    task automatic send(input bit with_eof, input bit clr_on_eof);
        for (int i = 0; i < flen; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == flen - 1);
            rx_byte  = frm[i];
            sts_clr  = clr_on_eof && with_eof && (i == flen - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof   = 1'b0;
        rx_eof   = 1'b0;
        sts_clr  = 1'b0;
    endtask

    task automatic clear_sts();
        @(negedge clk);
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    // sample right after the frame; pulse must be one cycle only
    task automatic expect_wake(input string req, input logic exp);
        chk(req, "wake_pulse", wake_pulse, exp);
        chk(req, "wake_sts", wake_sts, exp);
        @(negedge clk);
        chk(req, "pulse width", wake_pulse, 1'b0);
    endtask

    task automatic std_frame();
        start_frame();
        put(8'h33); put(8'h44);
        put_sync(6);
        put_copies(16, -1);
        put_crc();
    endtask

    task automatic t_reset();
        chk("R5", "reset wake_pulse", wake_pulse, 1'b0);
        chk("R5", "reset wake_sts", wake_sts, 1'b0);
    endtask

    task automatic t_basic();  // R1 R2 R5
        clear_sts();
        pwr_state = 2'b00; wake_en = 1'b1; frame_good = 1'b1;
        std_frame();
        send(1'b1, 1'b0);
        expect_wake("R1", 1'b1);
    endtask

    task automatic t_d0_disabled();  // R6
        clear_sts();
        pwr_state = 2'b00; wake_en = 1'b0;
        std_frame();
        send(1'b1, 1'b0);
        expect_wake("R6", 1'b0);
        wake_en = 1'b1;
    endtask

    task automatic t_d1_auto();  // R7
        clear_sts();
        pwr_state = 2'b01; wake_en = 1'b0;
        std_frame();
        send(1'b1, 1'b0);
        expect_wake("R7", 1'b1);
        pwr_state = 2'b00; wake_en = 1'b1;
    endtask

    task automatic t_other_state();  // R8
        clear_sts();
        pwr_state = 2'b10;
        std_frame();
        send(1'b1, 1'b0);
        expect_wake("R8", 1'b0);
        clear_sts();
        pwr_state = 2'b11;
        send(1'b1, 1'b0);
        expect_wake("R8", 1'b0);
        pwr_state = 2'b00;
    endtask

    task automatic t_bad_crc();  // R9
        clear_sts();
        frame_good = 1'b0;
        std_frame();
        send(1'b1, 1'b0);
        expect_wake("R9", 1'b0);
        frame_good = 1'b1;
    endtask

    task automatic t_wrong_addr();  // R2
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(16, 53);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R2", 1'b0);
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(15, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R2", 1'b0);
    endtask

    task automatic t_offset_long_sync();  // R3
        clear_sts();
        start_frame();
        for (int i = 0; i < 9; i++) put(8'h40 + 8'(i));
        put_sync(9);
        put_copies(16, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R3", 1'b1);
    endtask

    task automatic t_restart();  // R4
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(1, -1);
        put(8'h02); put(8'h1A);
        put_sync(6);           // first FF breaks the sequence, starts new run
        put_copies(16, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R4", 1'b1);
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(2, -1);
        put(8'h77);            // non-FF break
        put_sync(6);
        put_copies(16, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R4", 1'b1);
    endtask

    task automatic t_header_skip();  // R10
        clear_sts();
        flen = 0;
        put_sync(6);
        put_copies(1, -1);     // fills the 12 header bytes
        put_copies(15, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R10", 1'b0);
    endtask

    task automatic t_sticky();  // R11
        clear_sts();
        std_frame();
        send(1'b1, 1'b1);      // clear collides with the set
        chk("R11", "set beats clear", wake_sts, 1'b1);
        @(negedge clk);
        frame_good = 1'b0;
        send(1'b1, 1'b0);
        chk("R11", "status held", wake_sts, 1'b1);
        frame_good = 1'b1;
        clear_sts();
        chk("R11", "status cleared", wake_sts, 1'b0);
    endtask

    task automatic t_sof_reset();  // R12
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(16, -1);    // found, but the frame never ends
        send(1'b0, 1'b0);
        start_frame();
        put(8'h55);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R12", 1'b0);
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(8, -1);
        send(1'b0, 1'b0);
        start_frame();
        put_copies(8, -1);
        put_crc();
        send(1'b1, 1'b0);
        expect_wake("R12", 1'b0);
    endtask

    task automatic t_eof_completion();  // R13
        clear_sts();
        start_frame();
        put_sync(6);
        put_copies(16, -1);
        send(1'b1, 1'b0);
        expect_wake("R13", 1'b0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_d0_disabled();
        t_d1_auto();
        t_other_state();
        t_bad_crc();
        t_wrong_addr();
        t_offset_long_sync();
        t_restart();
        t_header_skip();
        t_sticky();
        t_sof_reset();
        t_eof_completion();
        t_basic();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule